// File: doc/BRIEF.md
# Idle-Gated MAC Soft Reset Controller

This block lets software reset a network MAC core by writing one control bit over a simple register port. The request is stored and held as pending. The reset is not applied at once: it waits for a clock cycle in which both the transmit and the receive DMA engines report idle, so that no bus transfer is cut off halfway. When that cycle comes, the controller drives a fixed-length reset pulse into the MAC logic. The same pulse returns the MAC configuration registers held here to their default value of zero. This includes the full-duplex mode bit.

The controller also records descriptor faults reported by the host side. The first fault event sets a sticky interrupt and stores the fault code. Neither of them can be cleared by the soft reset. Only the block reset `rst` clears them. Software polls the control bit to learn whether its reset has been carried out, and reads the status word to find out which fault occurred before it asks for a full hardware reset.

Register map: address 0 is the control word, with bit 0 as the reset request and pending flag. Address 1 is the read-only status word, with bit 0 as the fault flag and bits [ERR_W:1] as the fault code. Addresses 2 to 2+NUM_CFG-1 are the MAC configuration words. Bit 0 of address 2 is the full-duplex bit. Read data is registered and appears one cycle after the read address.

Top module: `mac_soft_reset_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `core_rst_o` and `host_err_irq_o` are 0, and every readable word (control, status, configuration) reads 0.
- R2: A write of 1 to bit 0 of address 0 sets the pending flag. Address 0 then reads 1 until the reset has completed.
- R3: `core_rst_o` stays low while a request is pending until a rising clock edge at which `tx_idle_i` and `rx_idle_i` are both high. It rises at that edge. One idle input alone never starts it.
- R4: Once started, `core_rst_o` stays high for exactly PULSE_LEN consecutive cycles (default 4).
- R5: The pending flag clears at the same edge at which `core_rst_o` falls. Address 0 reads 0 from then on.
- R6: The reset pulse clears every configuration word (addresses 2 to 2+NUM_CFG-1), including the full-duplex bit at bit 0 of address 2. Outside a pulse, configuration writes are stored and read back.
- R7: Writing 0 to address 0 has no effect. Writes of 1 while a request is pending neither add a second pulse nor lengthen the pulse.
- R8: An `err_evt_i` pulse sets `host_err_irq_o` at the next edge. Address 1 then reads bit 0 as 1 and bits [ERR_W:1] as the code from `err_code_i`. Later events leave the stored code unchanged.
- R9: The fault flag and code survive a soft reset, even when the fault event arrives at the same edge at which the pulse starts. Only `rst` clears them.
- R10: Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Registered read data, one cycle latency |
| tx_idle_i | input | 1 | Transmit DMA engine is idle |
| rx_idle_i | input | 1 | Receive DMA engine is idle |
| err_evt_i | input | 1 | Descriptor fault event, one cycle |
| err_code_i | input | ERR_W | Fault code that accompanies the event |
| core_rst_o | output | 1 | Reset pulse to the MAC logic |
| host_err_irq_o | output | 1 | Sticky fault interrupt |

## Verification
The assertions check the following on every cycle:
- the pulse never starts unless both idle inputs were high at the previous edge;
- the pulse lasts exactly PULSE_LEN cycles;
- the pending flag is high for the whole pulse and low once the pulse ends;
- the fault interrupt is sticky and follows each event;
- the stored fault code stays constant while the flag is set.

Some behaviour only the bench scenarios can show: what software reads back through the register port, that configuration words return to zero, that writes of 0 and repeated writes of 1 do nothing, and that a fault event in the same cycle as the pulse start survives the reset.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned STAT_ADDR = 1;
  localparam int unsigned CFG_BASE  = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_PULSE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/srst_seq.sv
module srst_seq
  import srst_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic tx_idle_i,
  input  logic rx_idle_i,
  output logic core_rst_o,
  output logic pending_o
);
  localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      cnt_q      <= '0;
      core_rst_o <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (req_i) state_q <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (tx_idle_i && rx_idle_i) begin
            state_q    <= SEQ_PULSE;
            cnt_q      <= CNT_LOAD;
            core_rst_o <= 1'b1;
          end
        end
        SEQ_PULSE: begin
          if (cnt_q == '0) begin
            state_q    <= SEQ_IDLE;
            core_rst_o <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign pending_o = (state_q != SEQ_IDLE);
endmodule

// File: rtl/srst_err_latch.sv
module srst_err_latch #(
  parameter int unsigned ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic [ERR_W-1:0] code_i,
  output logic             flag_o,
  output logic [ERR_W-1:0] code_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      code_o <= '0;
    end else if (evt_i && !flag_o) begin
      flag_o <= 1'b1;
      code_o <= code_i;
    end
  end
endmodule

// File: rtl/srst_cfg_regs.sv
module srst_cfg_regs #(
  parameter int unsigned NUM_CFG  = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned BASE     = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr_i,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [NUM_CFG-1:0][DATA_W-1:0] regs_o
);
  for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + gi);
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        regs_o[gi] <= '0;
      end else if (wr_en_i && (wr_addr_i == MY_ADDR)) begin
        regs_o[gi] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/mac_soft_reset_ctrl.sv
module mac_soft_reset_ctrl
  import srst_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned NUM_CFG   = 4,
  parameter int unsigned ERR_W     = 4,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              tx_idle_i,
  input  logic              rx_idle_i,
  input  logic              err_evt_i,
  input  logic [ERR_W-1:0]  err_code_i,
  output logic              core_rst_o,
  output logic              host_err_irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam int unsigned       PAD_W  = DATA_W - ERR_W - 1;

  logic                           req_wr;
  logic                           pending;
  logic [ERR_W-1:0]               err_code_q;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0]              rd_mux;

  assign req_wr = wr_en_i && (wr_addr_i == A_CTRL) && wr_data_i[0];

  srst_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_wr),
    .tx_idle_i  (tx_idle_i),
    .rx_idle_i  (rx_idle_i),
    .core_rst_o (core_rst_o),
    .pending_o  (pending)
  );

  srst_err_latch #(.ERR_W(ERR_W)) u_err (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (err_evt_i),
    .code_i (err_code_i),
    .flag_o (host_err_irq_o),
    .code_o (err_code_q)
  );

  srst_cfg_regs #(
    .NUM_CFG (NUM_CFG),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .BASE    (CFG_BASE)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (core_rst_o),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .regs_o    (cfg_q)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == A_CTRL) begin
      rd_mux = {{(DATA_W-1){1'b0}}, pending};
    end else if (rd_addr_i == A_STAT) begin
      rd_mux = {{PAD_W{1'b0}}, err_code_q, host_err_irq_o};
    end else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (rd_addr_i == ADDR_W'(CFG_BASE + i)) rd_mux = cfg_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_mux;
  end
endmodule

// File: rtl/mac_soft_reset_ctrl_chk.sv
module mac_soft_reset_ctrl_chk #(
  parameter int unsigned ERR_W     = 4,
  parameter int unsigned PULSE_LEN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_idle_i,
  input logic             rx_idle_i,
  input logic             err_evt_i,
  input logic             core_rst_o,
  input logic             pending,
  input logic             host_err_irq_o,
  input logic [ERR_W-1:0] err_code_q
);
  localparam int unsigned HC_W = $clog2(PULSE_LEN + 2) + 1;
  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)             hi_cnt <= '0;
    else if (core_rst_o) hi_cnt <= hi_cnt + 1'b1;
    else                 hi_cnt <= '0;
  end

  // R3
  start_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst_o) |-> $past(tx_idle_i && rx_idle_i));

  // R4
  pulse_not_long_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst_o |-> (hi_cnt < HC_W'(PULSE_LEN)));

  // R4
  pulse_full_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> (hi_cnt == HC_W'(PULSE_LEN)));

  // R5
  pending_during_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst_o |-> pending);

  // R5
  pending_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> !pending);

  // R8
  irq_follows_evt_chk: assert property (@(posedge clk) disable iff (rst)
    err_evt_i |=> host_err_irq_o);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    host_err_irq_o |=> host_err_irq_o);

  // R8
  code_held_chk: assert property (@(posedge clk) disable iff (rst)
    host_err_irq_o |=> $stable(err_code_q));
endmodule

bind mac_soft_reset_ctrl mac_soft_reset_ctrl_chk #(
  .ERR_W     (ERR_W),
  .PULSE_LEN (PULSE_LEN)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .tx_idle_i      (tx_idle_i),
  .rx_idle_i      (rx_idle_i),
  .err_evt_i      (err_evt_i),
  .core_rst_o     (core_rst_o),
  .pending        (pending),
  .host_err_irq_o (host_err_irq_o),
  .err_code_q     (err_code_q)
);

// File: tb/mac_soft_reset_ctrl_tb.sv
module mac_soft_reset_ctrl_tb;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned ERR_W  = 4;
  localparam int unsigned PLEN   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              tx_idle = 1'b0;
  logic              rx_idle = 1'b0;
  logic              err_evt = 1'b0;
  logic [ERR_W-1:0]  err_code = '0;
  logic              core_rst;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mac_soft_reset_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tx_idle_i(tx_idle), .rx_idle_i(rx_idle), .err_evt_i(err_evt),
    .err_code_i(err_code), .core_rst_o(core_rst), .host_err_irq_o(irq)
  );

  // addr[67:64], write data[63:32], expected readback[31:0]
  localparam logic [67:0] VEC [6] = '{
    {4'd2, 32'h0000_0001, 32'h0000_0001},
    {4'd3, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {4'd4, 32'h1234_5678, 32'h1234_5678},
    {4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {4'd1, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'd0, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive both idle inputs high and count the pulse length seen at negedges.
  task automatic run_pulse(output int len);
    len = 0;
    @(negedge clk);
    tx_idle = 1'b1; rx_idle = 1'b1;
    @(negedge clk);
    while (core_rst && len < 20) begin
      len++;
      @(negedge clk);
    end
    tx_idle = 1'b0; rx_idle = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    int len;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 core_rst", {31'b0, core_rst}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    for (int a = 0; a < 6; a++) begin
      rd(ADDR_W'(a), d);
      check("R1 readback", d, 0);
    end

    // table: R6 storage, R10 status read-only, R7 write of 0
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], d);
      check("R6 R7 R10 table", d, VEC[i][31:0]);
      check("R7 no pulse", {31'b0, core_rst}, 0);
    end

    // R2 request goes pending
    wr(0, 32'h1);
    rd(0, d);
    check("R2 pending", d, 1);
    // R7 extra writes of 1 while pending
    wr(0, 32'h1);
    wr(0, 32'hFFFF_FFFF);
    // R3 only one engine idle
    @(negedge clk); tx_idle = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 tx only", {31'b0, core_rst}, 0);
    tx_idle = 1'b0; rx_idle = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 rx only", {31'b0, core_rst}, 0);
    rx_idle = 1'b0;
    rd(0, d);
    check("R3 still pending", d, 1);
    rd_addr = 0;
    // R4 pulse length
    run_pulse(len);
    check("R4 pulse length", len, PLEN);
    check("R5 core_rst low", {31'b0, core_rst}, 0);
    rd(0, d);
    check("R5 pending cleared", d, 0);
    repeat (8) @(negedge clk);
    check("R7 no second pulse", {31'b0, core_rst}, 0);
    // R6 configuration cleared, duplex bit included
    for (int a = 2; a < 6; a++) begin
      rd(ADDR_W'(a), d);
      check("R6 cfg cleared", d, 0);
    end

    // R8 fault capture
    @(negedge clk); err_evt = 1'b1; err_code = 4'd5;
    @(negedge clk); err_evt = 1'b0;
    check("R8 irq set", {31'b0, irq}, 1);
    rd(1, d);
    check("R8 status", d, 32'h0000_000B);
    @(negedge clk); err_evt = 1'b1; err_code = 4'd3;
    @(negedge clk); err_evt = 1'b0;
    rd(1, d);
    check("R8 first code kept", d, 32'h0000_000B);
    // R9 survives a soft reset
    wr(0, 32'h1);
    run_pulse(len);
    check("R9 pulse", len, PLEN);
    check("R9 irq kept", {31'b0, irq}, 1);
    rd(1, d);
    check("R9 status kept", d, 32'h0000_000B);
    hw_reset();
    check("R9 irq cleared by rst", {31'b0, irq}, 0);
    rd(1, d);
    check("R9 status cleared", d, 0);

    // R9 fault arriving at the edge the pulse starts
    wr(0, 32'h1);
    @(negedge clk);
    tx_idle = 1'b1; rx_idle = 1'b1; err_evt = 1'b1; err_code = 4'd9;
    @(negedge clk);
    err_evt = 1'b0; tx_idle = 1'b0; rx_idle = 1'b0;
    check("R9 same-cycle pulse", {31'b0, core_rst}, 1);
    repeat (PLEN + 2) @(negedge clk);
    check("R9 same-cycle irq", {31'b0, irq}, 1);
    rd(1, d);
    check("R9 same-cycle code", d, 32'h0000_0013);
    rd(0, d);
    check("R5 pending after", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule